// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller collects up to 32 interrupt inputs and drives a single processor interrupt line. Software programs each input with a trigger type, a 3-bit priority and a vector word. When the processor takes the interrupt, it reads the acknowledge register. That read returns the vector of the winning input and records the winner's priority on a nesting stack. While the handler runs, only inputs of strictly higher priority can raise the line again. Each handler ends with a write to the end-of-interrupt register, which pops one nesting level.

An acknowledge read with no qualifying input returns a programmable spurious word and leaves the stack unchanged. Edge-triggered inputs latch their pending state until an acknowledge or a clear command removes it. Level-triggered inputs follow their pin. Enables are changed only through write-one set and clear commands.

The nesting stack is a three-state machine. NEST_EMPTY moves to NEST_ACTIVE on PUSH, which is an acknowledge read that finds a winner. NEST_ACTIVE moves to NEST_FULL on PUSH when one free level is left. NEST_ACTIVE moves back to NEST_EMPTY on POP, which is an end-of-interrupt write, when one level is left. NEST_FULL moves to NEST_ACTIVE on POP. A PUSH in NEST_FULL and a POP in NEST_EMPTY do nothing.

Top module: `vic_ctrl`

## Requirements
- R1: The mode word of source n sits at word address 0x00+n. Bits [2:0] hold the priority, where 7 is the most urgent. Bits [5:4] hold the trigger: 0 for high level, 1 for rising edge, 2 for low level, 3 for falling edge. The word reads back in the same layout.
- R2: Sources whose EXT_MASK bit is clear are internal. On an internal source, a mode write that selects trigger 2 or 3 keeps the old trigger and still stores the new priority.
- R3: Writing ones to 0x44 sets enable bits, and writing ones to 0x45 clears them. Zero bits leave their source unchanged. The enable mask reads at 0x43.
- R4: The pending set reads at 0x42. Writing ones to 0x46 clears the latched pending bit of an edge-triggered source. A level source whose pin is active stays pending.
- R5: `cpu_irq` is high exactly when an enabled pending source exists and either the stack is empty or the best such priority is strictly above the priority on top of the stack.
- R6: A read of 0x40 while `cpu_irq` is high returns the vector of the enabled pending source with the highest priority. Ties go to the lowest source number. The read pushes that source onto the stack. The vector word of source n sits at 0x20+n.
- R7: An acknowledge clears the pending latch of an edge-triggered winner. A level winner stays pending while its pin is active.
- R8: A read of 0x40 while `cpu_irq` is low returns the spurious word, which is read and written at 0x48, and pushes nothing. After such a read the status register at 0x41 reads 0 if the stack is empty.
- R9: The status register at 0x41 returns the source number on top of the stack, or 0 when the stack is empty.
- R10: Any write to 0x47, whatever the data, pops one level. A write to 0x47 on an empty stack changes nothing.
- R11: Eight writes to 0x47 empty the stack from any depth.
- R12: The stack holds at most 8 levels. When it is full, `cpu_irq` is low and an acknowledge returns the spurious word.
- R13: After reset, enables, pending bits, the spurious word, the status and `bus_rdata` are all 0, and `cpu_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Interrupt source pins |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Some rules are checked by assertions on every cycle:
- an acknowledge adds exactly one nesting level when the line is high;
- an acknowledge with the line low returns the spurious word;
- a full stack keeps the line low;
- the stack never overflows;
- a pop on an empty stack is inert;
- internal sources never take a low or falling trigger;
- an acknowledge clears an edge latch.

Only the bench scenarios can show the remaining rules. These are the winner's identity under equal priorities, the exact vector values, the nested order of status values, and the difference between edge and level sources under clear commands. Random priorities, enables and pin patterns are checked against a reference model in the bench.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_LOW  = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        NEST_EMPTY,
        NEST_ACTIVE,
        NEST_FULL
    } nest_state_e;

    // address regions (bits [6:5])
    localparam logic [1:0] REG_MODE = 2'b00;
    localparam logic [1:0] REG_VEC  = 2'b01;
    localparam logic [1:0] REG_CTL  = 2'b10;

    // control words within REG_CTL (bits [4:0])
    localparam logic [4:0] CTL_ACK    = 5'd0;
    localparam logic [4:0] CTL_STATUS = 5'd1;
    localparam logic [4:0] CTL_PEND   = 5'd2;
    localparam logic [4:0] CTL_EN     = 5'd3;
    localparam logic [4:0] CTL_EN_SET = 5'd4;
    localparam logic [4:0] CTL_EN_CLR = 5'd5;
    localparam logic [4:0] CTL_PCLR   = 5'd6;
    localparam logic [4:0] CTL_EOI    = 5'd7;
    localparam logic [4:0] CTL_SPUR   = 5'd8;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
    import vic_pkg::*;
#(
    parameter int   PRIO_W = 3,
    parameter int   VEC_W  = 32,
    parameter int   DATA_W = 32,
    parameter logic IS_EXT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_raw,
    input  logic              mode_we,
    input  logic              vec_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              pend_clr,
    output logic              req,
    output logic [PRIO_W-1:0] prio,
    output logic [VEC_W-1:0]  vector,
    output logic [DATA_W-1:0] mode_rd,
    output logic              pend,
    output logic              en
);
    logic              src_q, src_d2;
    trig_e             trig;
    trig_e             req_trig;
    logic [PRIO_W-1:0] prio_q;
    logic [VEC_W-1:0]  vec_q;
    logic              en_q, latch_q;
    logic              edge_now, level_on;

    assign req_trig = trig_e'(wdata[5:4]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= 1'b0;
            src_d2  <= 1'b0;
            trig    <= TRIG_HIGH;
            prio_q  <= '0;
            vec_q   <= '0;
            en_q    <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            src_q  <= src_raw;
            src_d2 <= src_q;
            if (mode_we) begin
                prio_q <= wdata[PRIO_W-1:0];
                // low-active triggers only for external sources
                if (IS_EXT || !wdata[5]) trig <= req_trig;
            end
            if (vec_we) vec_q <= wdata[VEC_W-1:0];
            if (en_set)      en_q <= 1'b1;
            else if (en_clr) en_q <= 1'b0;
            if (edge_now)      latch_q <= 1'b1;
            else if (pend_clr) latch_q <= 1'b0;
        end
    end

    always_comb begin
        edge_now = ((trig == TRIG_RISE) &&  src_q && !src_d2) ||
                   ((trig == TRIG_FALL) && !src_q &&  src_d2);
        level_on = ((trig == TRIG_HIGH) &&  src_q) ||
                   ((trig == TRIG_LOW)  && !src_q);
        pend     = level_on || (trig[0] && latch_q);
        req      = pend && en_q;
        prio     = prio_q;
        vector   = vec_q;
        en       = en_q;
        mode_rd  = '0;
        mode_rd[PRIO_W-1:0] = prio_q;
        mode_rd[5:4]        = trig;
    end

    p_internal_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !IS_EXT && wdata[5]) |=> (trig == $past(trig)));

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !edge_now) |=> !latch_q);

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic [NSRC-1:0]             req,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        any,
    output logic [IDX_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_prio
);
    // ascending scan with strict compare: equal priority keeps lower index
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!any || prio[i] > win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack
    import vic_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [IDX_W-1:0]  push_id,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [PRIO_W-1:0] top_prio,
    output logic [IDX_W-1:0]  top_id,
    output logic [CNT_W-1:0]  level
);
    nest_state_e       state, state_nx;
    logic [CNT_W-1:0]  level_nx;
    logic [CNT_W-1:0]  top_sel;
    logic [PTR_W-1:0]  wr_ptr, top_ptr;
    logic              do_push, do_pop;
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [IDX_W-1:0]  id_mem   [DEPTH];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= NEST_EMPTY;
            level <= '0;
        end else begin
            state <= state_nx;
            level <= level_nx;
        end
    end

    // transitions
    always_comb begin
        do_push  = push && (state != NEST_FULL);
        do_pop   = pop  && (state != NEST_EMPTY);
        state_nx = state;
        level_nx = level;
        if (do_push)     level_nx = level + 1'b1;
        else if (do_pop) level_nx = level - 1'b1;
        unique case (state)
            NEST_EMPTY: begin
                if (do_push) state_nx = (DEPTH == 1) ? NEST_FULL : NEST_ACTIVE;
            end
            NEST_ACTIVE: begin
                if (do_push && level == CNT_W'(DEPTH - 1)) state_nx = NEST_FULL;
                else if (do_pop && level == CNT_W'(1))     state_nx = NEST_EMPTY;
            end
            NEST_FULL: begin
                if (do_pop) state_nx = (DEPTH == 1) ? NEST_EMPTY : NEST_ACTIVE;
            end
            default: state_nx = NEST_EMPTY;
        endcase
    end

    assign wr_ptr  = level[PTR_W-1:0];
    assign top_sel = level - 1'b1;
    assign top_ptr = top_sel[PTR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                prio_mem[k] <= '0;
                id_mem[k]   <= '0;
            end
        end else if (do_push) begin
            prio_mem[wr_ptr] <= push_prio;
            id_mem[wr_ptr]   <= push_id;
        end
    end

    // outputs
    always_comb begin
        empty    = (state == NEST_EMPTY);
        full     = (state == NEST_FULL);
        top_prio = empty ? '0 : prio_mem[top_ptr];
        top_id   = empty ? '0 : id_mem[top_ptr];
    end

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    p_pop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int              NSRC     = 32,
    parameter int              PRIO_W   = 3,
    parameter int              VEC_W    = 32,
    parameter int              DATA_W   = 32,
    parameter int              DEPTH    = 8,
    parameter logic [NSRC-1:0] EXT_MASK = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]  region;
    logic [4:0]  sub;
    logic        wr, rd, ctl_wr, ack_rd, ack_hit, eoi_wr;

    logic [NSRC-1:0]              req_vec, pend_vec, en_vec;
    logic [NSRC-1:0][PRIO_W-1:0]  prio_all;
    logic [NSRC-1:0][VEC_W-1:0]   vec_all;
    logic [NSRC-1:0][DATA_W-1:0]  mode_all;

    logic              any;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              stk_empty, stk_full;
    logic [PRIO_W-1:0] top_prio;
    logic [IDX_W-1:0]  top_id;
    logic [CNT_W-1:0]  stk_level;
    logic [VEC_W-1:0]  spur_q;
    logic [DATA_W-1:0] rd_next;

    assign region  = bus_addr[ADDR_W-1:5];
    assign sub     = bus_addr[4:0];
    assign wr      = bus_sel && bus_wr;
    assign rd      = bus_sel && !bus_wr;
    assign ctl_wr  = wr && (region == REG_CTL);
    assign ack_rd  = rd && (region == REG_CTL) && (sub == CTL_ACK);
    assign eoi_wr  = ctl_wr && (sub == CTL_EOI);
    assign cpu_irq = any && (stk_empty || (win_prio > top_prio));
    assign ack_hit = ack_rd && cpu_irq;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vic_src_cell #(
            .PRIO_W (PRIO_W),
            .VEC_W  (VEC_W),
            .DATA_W (DATA_W),
            .IS_EXT (EXT_MASK[g])
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_raw  (src_in[g]),
            .mode_we  (wr && (region == REG_MODE) && (sub == 5'(g))),
            .vec_we   (wr && (region == REG_VEC)  && (sub == 5'(g))),
            .wdata    (bus_wdata),
            .en_set   (ctl_wr && (sub == CTL_EN_SET) && bus_wdata[g]),
            .en_clr   (ctl_wr && (sub == CTL_EN_CLR) && bus_wdata[g]),
            .pend_clr ((ctl_wr && (sub == CTL_PCLR) && bus_wdata[g]) ||
                       (ack_hit && (win_idx == IDX_W'(g)))),
            .req      (req_vec[g]),
            .prio     (prio_all[g]),
            .vector   (vec_all[g]),
            .mode_rd  (mode_all[g]),
            .pend     (pend_vec[g]),
            .en       (en_vec[g])
        );
    end

    vic_arbiter #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .req      (req_vec),
        .prio     (prio_all),
        .any      (any),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    vic_nest_stack #(
        .DEPTH  (DEPTH),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_hit),
        .push_prio (win_prio),
        .push_id   (win_idx),
        .pop       (eoi_wr),
        .empty     (stk_empty),
        .full      (stk_full),
        .top_prio  (top_prio),
        .top_id    (top_id),
        .level     (stk_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           spur_q <= '0;
        else if (ctl_wr && sub == CTL_SPUR)   spur_q <= bus_wdata[VEC_W-1:0];
    end

    always_comb begin
        rd_next = '0;
        unique case (region)
            REG_MODE: begin
                for (int i = 0; i < NSRC; i++)
                    if (sub == 5'(i)) rd_next = mode_all[i];
            end
            REG_VEC: begin
                for (int i = 0; i < NSRC; i++)
                    if (sub == 5'(i)) rd_next = DATA_W'(vec_all[i]);
            end
            REG_CTL: begin
                case (sub)
                    CTL_ACK:    rd_next = cpu_irq ? DATA_W'(vec_all[win_idx])
                                                  : DATA_W'(spur_q);
                    CTL_STATUS: rd_next = DATA_W'(top_id);
                    CTL_PEND:   rd_next = DATA_W'(pend_vec);
                    CTL_EN:     rd_next = DATA_W'(en_vec);
                    CTL_SPUR:   rd_next = DATA_W'(spur_q);
                    default:    rd_next = '0;
                endcase
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_next;
    end

    p_ack_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && cpu_irq) |=> (stk_level == $past(stk_level) + 1'b1));

    p_spur_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !cpu_irq) |=> (bus_rdata == DATA_W'($past(spur_q)) &&
                                  stk_level == $past(stk_level)));

    p_full_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !cpu_irq);

    p_win_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> req_vec[win_idx]);
endmodule

// File: tb/test_vic_ctrl.sv
`timescale 1ns/1ps
module test_vic_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail = 0;

    // reference model for the random phase (all sources high level)
    int          m_prio [32];
    logic [31:0] m_vec  [32];
    logic [31:0] m_en;
    int          stk_prio [8];
    int          stk_id   [8];
    int          depth;

    always #2.5 clk = ~clk;

    vic_ctrl i_vic_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // model: winner index or -1 when nothing qualifies
    function automatic int pick(output int wp);
        int best = -1;
        wp = 0;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && src_in[i] && (best < 0 || m_prio[i] > wp)) begin
                best = i;
                wp = m_prio[i];
            end
        if (best >= 0 && depth > 0 && wp <= stk_prio[depth-1]) best = -1;
        return best;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int w, wp;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 rdata", bus_rdata, 32'h0);
        check("R13 irq", {31'b0, cpu_irq}, 32'h0);
        rd(7'h43, d); check("R13 enables", d, 32'h0);
        rd(7'h42, d); check("R13 pending", d, 32'h0);
        rd(7'h48, d); check("R13 spurious", d, 32'h0);
        rd(7'h41, d); check("R13 status", d, 32'h0);

        // R3 enable set/clear
        wr(7'h44, 32'h0000_00F0); rd(7'h43, d); check("R3 set", d, 32'h0000_00F0);
        wr(7'h44, 32'h0000_0003); rd(7'h43, d); check("R3 set keeps", d, 32'h0000_00F3);
        wr(7'h45, 32'h0000_0010); rd(7'h43, d); check("R3 clear", d, 32'h0000_00E3);
        wr(7'h45, 32'h0);         rd(7'h43, d); check("R3 zero clear", d, 32'h0000_00E3);
        wr(7'h45, 32'hFFFF_FFFF);

        // R1/R2 mode layout and internal restriction
        wr(7'h1E, 32'h32); rd(7'h1E, d); check("R1 mode ext fall", d, 32'h32);
        wr(7'h03, 32'h01);
        wr(7'h03, 32'h25); rd(7'h03, d); check("R2 internal low rejected", d, 32'h05);
        wr(7'h03, 32'h36); rd(7'h03, d); check("R2 internal fall rejected", d, 32'h06);

        // R4/R1 falling edge on source 30
        set_src(32'h4000_0000);
        set_src(32'h0);
        rd(7'h42, d); check("R1 falling latched", d, 32'h4000_0000);
        wr(7'h44, 32'h4000_0000);
        check("R5 irq edge", {31'b0, cpu_irq}, 32'h1);
        wr(7'h46, 32'h4000_0000);
        rd(7'h42, d); check("R4 clear edge", d, 32'h0);
        check("R5 irq off", {31'b0, cpu_irq}, 32'h0);

        // R7 acknowledge clears edge latch; R9 status
        wr(7'h3E, 32'hA5A5_0030);
        set_src(32'h4000_0000);
        set_src(32'h0);
        rd(7'h40, d); check("R6 edge vector", d, 32'hA5A5_0030);
        rd(7'h42, d); check("R7 edge cleared on ack", d, 32'h0);
        rd(7'h41, d); check("R9 status 30", d, 32'd30);
        wr(7'h47, 32'h1234);
        rd(7'h41, d); check("R10 pop to empty", d, 32'h0);

        // R1 low level on source 31, R4 level unaffected by clear
        wr(7'h1F, 32'h24);
        set_src(32'h8000_0000);
        rd(7'h42, d); check("R1 low level idle", d, 32'h0);
        set_src(32'h0);
        rd(7'h42, d); check("R1 low level active", d, 32'h8000_0000);
        wr(7'h46, 32'h8000_0000);
        rd(7'h42, d); check("R4 level stays", d, 32'h8000_0000);
        wr(7'h1F, 32'h0);

        // R1 rising edge on source 4
        wr(7'h04, 32'h13);
        set_src(32'h0000_0010);
        set_src(32'h0);
        rd(7'h42, d); check("R1 rising latched", d, 32'h0000_0010);
        wr(7'h46, 32'hFFFF_FFFF);
        wr(7'h04, 32'h0); wr(7'h1E, 32'h0);

        // R8 spurious
        wr(7'h45, 32'hFFFF_FFFF);
        wr(7'h48, 32'hDEAD_BEEF);
        rd(7'h48, d); check("R8 spurious readback", d, 32'hDEAD_BEEF);
        rd(7'h40, d); check("R8 spurious ack", d, 32'hDEAD_BEEF);
        rd(7'h41, d); check("R8 status zero", d, 32'h0);
        wr(7'h47, 32'h0);
        rd(7'h41, d); check("R10 empty pop inert", d, 32'h0);

        // R6 ties and R5 nesting
        wr(7'h05, 32'h2); wr(7'h09, 32'h2); wr(7'h0C, 32'h6);
        wr(7'h25, 32'h555); wr(7'h29, 32'h999); wr(7'h2C, 32'hCCC);
        wr(7'h44, 32'h0000_1220);
        set_src(32'h0000_0220);
        rd(7'h40, d); check("R6 tie lowest", d, 32'h555);
        rd(7'h41, d); check("R9 status 5", d, 32'd5);
        check("R5 equal prio blocked", {31'b0, cpu_irq}, 32'h0);
        rd(7'h42, d); check("R7 level stays after ack", d, 32'h0000_0220);
        set_src(32'h0000_1220);
        check("R5 higher prio raises", {31'b0, cpu_irq}, 32'h1);
        rd(7'h40, d); check("R6 nested vector", d, 32'hCCC);
        rd(7'h41, d); check("R9 status 12", d, 32'd12);
        wr(7'h47, 32'h0);
        rd(7'h41, d); check("R10 back to 5", d, 32'd5);
        wr(7'h47, 32'hFFFF_FFFF);
        rd(7'h41, d); check("R10 empty again", d, 32'h0);
        check("R5 empty raises", {31'b0, cpu_irq}, 32'h1);

        // R11/R12 eight levels
        wr(7'h45, 32'hFFFF_FFFF);
        set_src(32'h0);
        for (int i = 0; i < 8; i++) begin
            wr(7'(i), 32'(i));
            wr(7'(32 + i), 32'h100 + 32'(i));
        end
        wr(7'h44, 32'h0000_00FF);
        for (int k = 0; k < 8; k++) begin
            set_src(32'((1 << (k + 1)) - 1));
            rd(7'h40, d); check("R6 nest step", d, 32'h100 + 32'(k));
        end
        rd(7'h41, d); check("R12 status at full", d, 32'd7);
        check("R12 full irq low", {31'b0, cpu_irq}, 32'h0);
        rd(7'h40, d); check("R12 full ack spurious", d, 32'hDEAD_BEEF);
        for (int k = 0; k < 8; k++) wr(7'h47, 32'h0);
        rd(7'h41, d); check("R11 unwound", d, 32'h0);
        check("R11 irq after unwind", {31'b0, cpu_irq}, 32'h1);

        // cleanup for random phase
        wr(7'h45, 32'hFFFF_FFFF);
        set_src(32'h0);
        for (int k = 0; k < 8; k++) wr(7'h47, 32'h0);
        m_en = '0;
        depth = 0;

        // random phase: R5/R6/R9/R10
        for (int it = 0; it < 60; it++) begin
            if (it % 15 == 0) begin
                for (int i = 0; i < 32; i++) begin
                    m_prio[i] = int'($urandom_range(7));
                    m_vec[i]  = $urandom;
                    wr(7'(i), 32'(m_prio[i]));
                    wr(7'(32 + i), m_vec[i]);
                end
            end
            begin
                logic [31:0] s, c;
                s = $urandom & $urandom & $urandom;
                c = $urandom & $urandom;
                wr(7'h44, s); m_en = m_en | s;
                wr(7'h45, c); m_en = m_en & ~c;
                set_src($urandom & $urandom);
            end
            w = pick(wp);
            check("R5 random irq", {31'b0, cpu_irq}, (w >= 0) ? 32'h1 : 32'h0);
            rd(7'h40, d);
            if (w >= 0) begin
                check("R6 random vector", d, m_vec[w]);
                stk_prio[depth] = wp;
                stk_id[depth] = w;
                depth++;
            end else begin
                check("R8 random spurious", d, 32'hDEAD_BEEF);
            end
            rd(7'h41, d);
            check("R9 random status", d, (depth > 0) ? 32'(stk_id[depth-1]) : 32'h0);
            if ($urandom_range(1) == 1) begin
                wr(7'h47, $urandom);
                if (depth > 0) depth--;
            end
        end

        finish_run();
    end
endmodule